// File: doc/BRIEF.md
# Dual-Reload PWM Timer

This block is a down-counting timer that produces a pulse-width-modulated waveform without processor help between periods. Software writes two reload values. When the counter passes through zero, it is refilled from one of them, and the two values are used in turn. Each of these underflows can invert the output pin, so one reload value sets how long the pin stays in one level and the other sets how long it stays in the other level.

Each underflow also sets one of two sticky pending flags. Which flag is set depends on which reload value the underflow loaded. Two enables decide which pending flags raise the single interrupt request. The counter advances only on cycles where the tick input is high, so an outside prescaler or an instruction-cycle strobe sets the time base. A 3-bit control field selects the PWM mode. Any other value in that field parks the block.

Top module: `dual_reload_pwm_timer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, pwm_out, pend_a, pend_b and irq are all 0, and both reload registers hold 0.
- R2: In PWM mode the counter drops by one on each clock where tick is 1 and holds its value where tick is 0. With tick held at 1 and a reload value of N, a phase lasts N+1 clocks.
- R3: The first underflow after entering PWM mode reloads from register A. Later underflows alternate, starting with register B, then A, then B, and so on.
- R4: While tog_en is 1, each underflow inverts pwm_out. While tog_en is 0, pwm_out keeps its level. On entry to PWM mode pwm_out is 0.
- R5: An underflow that reloads from A sets pend_a. An underflow that reloads from B sets pend_b. A single underflow never sets both flags.
- R6: A pending flag stays at 1 until its clear strobe (clr_a or clr_b) is 1 at a clock edge. A clear drives the flag to 0 on the next cycle.
- R7: irq is 1 exactly when (pend_a and ien_a) or (pend_b and ien_b) is true.
- R8: PWM mode is active only while mode equals 3'b101. On any other value the counter stops, pwm_out is 0 from the next cycle, and no pending flag is set; clears still work. Returning to 3'b101 counts as a fresh entry.
- R9: If a clear strobe and an underflow that sets the same flag occur at the same edge, the flag ends up at 1.
- R10: A write (wr_a or wr_b with wr_data) changes only the stored reload value. It does not alter the running count and takes effect at the next reload from that register; a reload at the same edge as the write uses the old value.
- R11: An underflow is a tick that finds the count at 0. At that edge the count loads the selected reload value and never wraps to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one per time-base step |
| mode | input | 3 | Timer control field; 3'b101 selects PWM |
| tog_en | input | 1 | Invert pwm_out on each underflow |
| wr_a | input | 1 | Write wr_data into reload register A |
| wr_b | input | 1 | Write wr_data into reload register B |
| wr_data | input | 16 | Reload value to write |
| clr_a | input | 1 | Clear pending flag A |
| clr_b | input | 1 | Clear pending flag B |
| ien_a | input | 1 | Interrupt enable for flag A |
| ien_b | input | 1 | Interrupt enable for flag B |
| pwm_out | output | 1 | PWM waveform |
| pend_a | output | 1 | Pending flag for reloads from A |
| pend_b | output | 1 | Pending flag for reloads from B |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench checks the first-reload rule directly. A design that began the alternation with B would set pend_b on the first underflow and swap the high and low phase lengths. Directed cases also cover a clear that lands in the same cycle as an underflow (a design where the clear wins would drop the event), a reload value of 0 (a design that wrapped would produce a phase of 65536 clocks), and a reload write during a running phase (a design that copied the value straight into the count would shorten or stretch that phase). Random traffic then mixes tick gaps, mode exits and re-entries, enable changes and writes, and compares the design against a cycle model on every clock.

// File: rtl/dual_reload_pwm_timer.sv
module dual_reload_pwm_timer #(
  parameter int          W        = 16,
  parameter logic [2:0]  PWM_MODE = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic         tog_en,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [15:0]  wr_data,
  input  logic         clr_a,
  input  logic         clr_b,
  input  logic         ien_a,
  input  logic         ien_b,
  output logic         pwm_out,
  output logic         pend_a,
  output logic         pend_b,
  output logic         irq
);

  logic [W-1:0] rel_a, rel_b, cnt;
  logic         armed, next_b;

  wire active = (mode == PWM_MODE);
  wire run    = active && armed && tick;
  wire undfl  = run && (cnt == '0);
  wire set_a  = undfl && !next_b;
  wire set_b  = undfl &&  next_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_a <= '0;
      rel_b <= '0;
    end else begin
      if (wr_a) rel_a <= wr_data[W-1:0];
      if (wr_b) rel_b <= wr_data[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      next_b  <= 1'b0;
      pwm_out <= 1'b0;
    end else if (!active) begin
      armed   <= 1'b0;
      pwm_out <= 1'b0;
    end else if (!armed) begin
      cnt     <= rel_a;
      armed   <= 1'b1;
      next_b  <= 1'b0;
      pwm_out <= 1'b0;
    end else if (undfl) begin
      cnt     <= next_b ? rel_b : rel_a;
      next_b  <= !next_b;
      if (tog_en) pwm_out <= !pwm_out;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      pend_a <= (pend_a && !clr_a) || set_a;
      pend_b <= (pend_b && !clr_b) || set_b;
    end
  end

  assign irq = (pend_a && ien_a) || (pend_b && ien_b);

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter logic [2:0] PWM_MODE = 3'b101
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       tog_en,
  input logic       armed,
  input logic       clr_a,
  input logic       clr_b,
  input logic       ien_a,
  input logic       ien_b,
  input logic       pwm_out,
  input logic       pend_a,
  input logic       pend_b,
  input logic       irq
);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((pend_a && ien_a) || (pend_b && ien_b)));

  p_sticky_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a && !clr_a) |=> pend_a);

  p_sticky_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_b && !clr_b) |=> pend_b);

  p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_a) |-> !$rose(pend_b));

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PWM_MODE) |=> !pwm_out);

  p_hold_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PWM_MODE && armed && !tog_en) |=> $stable(pwm_out));

endmodule

bind dual_reload_pwm_timer pwm_timer_checker #(.PWM_MODE(PWM_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tog_en(tog_en), .armed(armed),
  .clr_a(clr_a), .clr_b(clr_b), .ien_a(ien_a), .ien_b(ien_b),
  .pwm_out(pwm_out), .pend_a(pend_a), .pend_b(pend_b), .irq(irq)
);

// File: tb/test_dual_reload_pwm_timer.sv
`timescale 1ns/1ps
module test_dual_reload_pwm_timer;
  localparam logic [2:0] PWM = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, tog_en = 0, wr_a = 0, wr_b = 0, clr_a = 0, clr_b = 0, ien_a = 0, ien_b = 0;
  logic [2:0]  mode = 3'b000;
  logic [15:0] wr_data = 0;
  logic pwm_out, pend_a, pend_b, irq;

  int n_vec = 0, n_bad = 0;
  string tag = "R1";

  logic        m_armed = 0, m_nb = 0, m_pwm = 0, m_pa = 0, m_pb = 0;
  logic [15:0] m_cnt = 0, m_ra = 0, m_rb = 0;

  always #5 clk = ~clk;

  dual_reload_pwm_timer i_dual_reload_pwm_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .tog_en(tog_en),
    .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data), .clr_a(clr_a), .clr_b(clr_b),
    .ien_a(ien_a), .ien_b(ien_b), .pwm_out(pwm_out), .pend_a(pend_a),
    .pend_b(pend_b), .irq(irq)
  );

  function automatic logic exp_irq(logic pa, logic pb, logic ea, logic eb);
    return (pa && ea) || (pb && eb);
  endfunction

  task automatic check(string t, string what, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic model_next();
    logic sa, sb;
    sa = 0; sb = 0;
    if (mode == PWM) begin
      if (!m_armed) begin
        m_cnt = m_ra; m_pwm = 0; m_nb = 0; m_armed = 1;
      end else if (tick) begin
        if (m_cnt == 0) begin
          m_cnt = m_nb ? m_rb : m_ra;
          if (m_nb) sb = 1; else sa = 1;
          m_nb = !m_nb;
          if (tog_en) m_pwm = !m_pwm;
        end else m_cnt = m_cnt - 1;
      end
    end else begin
      m_armed = 0; m_pwm = 0;
    end
    m_pa = (m_pa && !clr_a) || sa;
    m_pb = (m_pb && !clr_b) || sb;
    if (wr_a) m_ra = wr_data;
    if (wr_b) m_rb = wr_data;
  endtask

  task automatic compare_all();
    check({tag, " R4"}, "pwm_out", 16'(pwm_out), 16'(m_pwm));
    check({tag, " R5"}, "pend_a", 16'(pend_a), 16'(m_pa));
    check({tag, " R5"}, "pend_b", 16'(pend_b), 16'(m_pb));
    check({tag, " R7"}, "irq", 16'(irq), 16'(exp_irq(m_pa, m_pb, ien_a, ien_b)));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_next();
      @(negedge clk);
      compare_all();
      wr_a = 0; wr_b = 0; clr_a = 0; clr_b = 0;
    end
  endtask

  task automatic wr_reload(logic sel_b, logic [15:0] v);
    wr_data = v; wr_a = !sel_b; wr_b = sel_b;
  endtask

  initial begin
    #(150000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", "pwm_out in reset", 16'(pwm_out), 0);
    check("R1", "irq in reset", 16'(irq), 0);
    rst_n = 1;
    step();
    check("R1", "pend_a after reset", 16'(pend_a), 0);
    check("R1", "pend_b after reset", 16'(pend_b), 0);

    tag = "R3";
    ien_a = 1; ien_b = 1; tog_en = 1; tick = 1;
    wr_reload(0, 16'd3); step();
    wr_reload(1, 16'd5); step();
    mode = PWM;
    step(4);
    check("R3", "pend_a before first underflow", 16'(pend_a), 0);
    step();
    check("R3", "pend_a on first underflow", 16'(pend_a), 1);
    check("R3", "pend_b on first underflow", 16'(pend_b), 0);
    check("R4", "pwm_out after first toggle", 16'(pwm_out), 1);
    check("R7", "irq from flag A", 16'(irq), 1);
    step(3);
    check("R2", "phase A still high", 16'(pwm_out), 1);
    step();
    check("R3", "second underflow sets pend_b", 16'(pend_b), 1);
    check("R2", "pwm_out low after A+1 clocks", 16'(pwm_out), 0);

    tag = "R6";
    ien_a = 0; step();
    check("R7", "masked A still shows B irq", 16'(irq), 1);
    clr_b = 1; step();
    check("R6", "pend_b cleared", 16'(pend_b), 0);
    check("R6", "pend_a held", 16'(pend_a), 1);
    ien_a = 1;

    tag = "R2";
    tick = 0; step(20);
    check("R2", "no underflow without ticks", 16'(pend_b), 0);
    tick = 1;

    tag = "R9";
    clr_a = 1; step();
    while (!(pwm_out == 1'b0 && m_cnt == 0 && m_nb == 1'b0)) step();
    clr_a = 1; step();
    check("R9", "set wins over clear", 16'(pend_a), 1);

    tag = "R10";
    while (!(m_cnt == 2 && m_nb == 1'b1)) step();
    wr_reload(1, 16'd9); step();
    step(2);
    check("R10", "running count not disturbed", 16'(pwm_out), 0);
    step(9);
    check("R10", "new B value used", 16'(pwm_out), 0);
    step();
    check("R10", "B phase ends after 10 clocks", 16'(pwm_out), 1);

    tag = "R11";
    mode = 3'b000;
    wr_reload(0, 16'd0); step();
    check("R8", "pwm low when idle", 16'(pwm_out), 0);
    wr_reload(1, 16'd0); clr_a = 1; clr_b = 1; step(5);
    check("R8", "no pending while idle", 16'(pend_a | pend_b), 0);
    mode = PWM; step(2);
    check("R11", "zero reload underflows at once", 16'(pend_a), 1);
    step();
    check("R11", "next tick reloads B", 16'(pend_b), 1);

    tag = "R4";
    tog_en = 0; step(8);
    tog_en = 1;

    tag = "rand";
    for (int i = 0; i < 4000; i++) begin
      tick   = ($urandom % 4) != 0;
      if ($urandom % 150 == 0) mode = (mode == PWM) ? 3'($urandom % 5) : PWM;
      if ($urandom % 40 == 0) tog_en = ~tog_en;
      if ($urandom % 20 == 0) ien_a = $urandom;
      if ($urandom % 20 == 0) ien_b = $urandom;
      if ($urandom % 10 == 0) wr_reload($urandom, 16'($urandom % 12));
      clr_a = ($urandom % 8) == 0;
      clr_b = ($urandom % 8) == 0;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule